// File: doc/BRIEF.md
# Byte-Stream Packet Egress Deframer

This block takes bytes from an upstream packet buffer and presents them to a sink on a byte-wide port. The port has a data-available flag, the byte itself, and a packet marker (sync) with its own output-enable. The sink holds the stream off one byte at a time with its enable input. A byte is handed over in every clock cycle where enable and data-available are both high.

A two-bit mode input sets how packets are framed. In fixed mode, packets have a programmed length and the sync pin is not driven. In first-marker mode, packets have the same programmed length and sync is high on the first byte of each packet. In last-marker mode, packets have variable length: the buffer flags the final byte, and sync is high on that byte. In the two fixed-length modes, a packet does not start until all of its bytes are in the buffer. In last-marker mode, any buffered byte may start a packet.

The buffer side is a show-ahead interface. The buffer presents its head byte, that byte's end flag and its fill level. The block pulses a pop strobe in each cycle where it takes the head byte into its output register.

Top module: `egress_deframer`

## Requirements
- R1: After reset, avail_o, sync_o, buf_pop_o and data_o are all 0.
- R2: A byte is handed to the sink only in a cycle where avail_o and sink_en_i are both high. Bytes reach the sink in buffer order, one pop per byte. With enable held high and data buffered, a new byte is presented every cycle.
- R3: While sink_en_i is low and avail_o is high, data_o, avail_o and sync_o keep their values.
- R4: In fixed and first-marker modes (mode_i 0 and 1, with 3 acting as 0), no packet starts while buf_level_i is below cfg_len_i. Once the level reaches cfg_len_i, avail_o rises with the first byte on data_o.
- R5: sync_oe_o is low in fixed mode (mode_i 0 or 3) and high in first-marker (1) and last-marker (2) modes.
- R6: In first-marker mode, sync_o is high exactly while the first byte of each packet is presented.
- R7: In last-marker mode, sync_o is high exactly while a byte whose buf_last_i flag was set is presented. A single buffered byte is enough to start a packet.
- R8: avail_o is low in the cycle after the final byte of a packet is taken if no further data is ready. Otherwise the next packet follows with no idle cycle.
- R9: While avail_o is low, sync_o is low and data_o keeps the last byte presented.
- R10: In the fixed-length modes, every packet is exactly cfg_len_i bytes long (cfg_len_i must be at least 1). The byte after cfg_len_i bytes starts a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Framing mode: 0 fixed, 1 first-marker, 2 last-marker, 3 as 0 |
| cfg_len_i | input | LEN_W | Packet length in bytes for the fixed-length modes |
| buf_data_i | input | DATA_W | Head byte of the upstream buffer |
| buf_last_i | input | 1 | Head byte ends its packet (last-marker mode) |
| buf_level_i | input | LVL_W | Number of bytes held in the buffer |
| buf_pop_o | output | 1 | Head byte is taken this cycle |
| sink_en_i | input | 1 | Sink enable; low holds the current byte |
| avail_o | output | 1 | A valid byte is on data_o |
| data_o | output | DATA_W | Output byte |
| sync_o | output | 1 | Packet marker value |
| sync_oe_o | output | 1 | Output enable for the sync pin |

## Verification
A corrupt byte index in the fixed-length modes shows up in first-marker mode as a sync pulse that arrives early, late or not at all within one packet length. In fixed mode it can only be seen when avail_o drops too early or too late at the end of a packet. A wrong packet-open flag either starts a packet before the whole packet is buffered, which is visible as soon as avail_o rises, or misplaces the next marker. A fault in the output register shows as a byte that changes or is skipped during a hold-off, or a data-available flag that stays high after the last byte. Either is visible on the first cycle after the handover.

// File: rtl/dfr_pkg.sv
// Shared definitions for the egress deframer.
// Assumes: the mode code is static while a packet is in flight.
package dfr_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED = 2'd0,
        MODE_FIRST = 2'd1,
        MODE_LAST  = 2'd2,
        MODE_ALT   = 2'd3
    } dfr_mode_e;

    // Fixed-length framing applies to every code except last-marker.
    function automatic logic is_fixed_len(input logic [1:0] m);
        return m != MODE_LAST;
    endfunction

endpackage

// File: rtl/dfr_pos_counter.sv
// Byte position tracker: remembers the index of the last byte loaded
// and whether that byte left its packet open.
// Assumes: load_is_last is valid whenever load is high.
module dfr_pos_counter #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_is_last,
    output logic             pkt_open,
    output logic [LEN_W-1:0] next_idx
);

    logic [LEN_W-1:0] idx_q;
    logic             open_q;

    // Index of the byte that would be loaded next.
    always_comb begin
        next_idx = open_q ? idx_q + 1'b1 : '0;
    end

    // Advance position and packet-open flag on each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            open_q <= 1'b0;
        end else if (load) begin
            idx_q  <= next_idx;
            open_q <= !load_is_last;
        end
    end

    assign pkt_open = open_q;

endmodule

// File: rtl/dfr_load_ctrl.sv
// Load decision: picks when the buffer head may enter the output stage
// and classifies it as first and/or last byte of its packet.
// Assumes: cfg_len >= 1; in fixed-length modes a started packet is
// entirely buffered, so a mid-packet byte is always present.
module dfr_load_ctrl
    import dfr_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int LVL_W = 10
) (
    input  logic [1:0]       mode,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [LVL_W-1:0] buf_level,
    input  logic             buf_last,
    input  logic             pkt_open,
    input  logic [LEN_W-1:0] next_idx,
    input  logic             slot_free,
    output logic             load,
    output logic             load_is_first,
    output logic             load_is_last
);

    localparam int CMP_W = (LVL_W > LEN_W) ? LVL_W : LEN_W;

    logic fixed;
    logic have_byte;
    logic have_pkt;

    // Data readiness: one byte mid-packet, a whole packet to start fixed.
    always_comb begin
        fixed     = is_fixed_len(mode);
        have_byte = buf_level != '0;
        have_pkt  = CMP_W'(buf_level) >= CMP_W'(cfg_len);
        if (pkt_open || !fixed) begin
            load = slot_free && have_byte;
        end else begin
            load = slot_free && have_pkt && have_byte;
        end
    end

    // Packet boundary classification of the byte being loaded.
    always_comb begin
        load_is_first = !pkt_open;
        load_is_last  = fixed ? (next_idx == cfg_len - 1'b1) : buf_last;
    end

endmodule

// File: rtl/dfr_out_stage.sv
// Output register: holds the presented byte, its availability and its
// boundary flags; generates the sync value and its output enable.
// Assumes: load is only raised when slot_free is high.
module dfr_out_stage
    import dfr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              sink_en,
    input  logic              load,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    output logic              slot_free,
    output logic              avail,
    output logic [DATA_W-1:0] data,
    output logic              sync,
    output logic              sync_oe
);

    logic [DATA_W-1:0] data_q;
    logic              avail_q;
    logic              first_q;
    logic              last_q;

    // The slot frees when empty or when the sink takes its byte.
    assign slot_free = !avail_q || sink_en;

    // Capture a new byte, or empty the slot after a handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            avail_q <= 1'b0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (load) begin
            data_q  <= in_data;
            avail_q <= 1'b1;
            first_q <= in_first;
            last_q  <= in_last;
        end else if (slot_free) begin
            avail_q <= 1'b0;
        end
    end

    // Marker value per mode, forced low when nothing is presented.
    always_comb begin
        unique case (mode)
            MODE_FIRST: sync = avail_q && first_q;
            MODE_LAST:  sync = avail_q && last_q;
            default:    sync = 1'b0;
        endcase
        sync_oe = (mode == MODE_FIRST) || (mode == MODE_LAST);
    end

    assign avail = avail_q;
    assign data  = data_q;

endmodule

// File: rtl/egress_deframer.sv
// Egress deframer top: reads packets from a show-ahead buffer and
// streams them to a byte-wide sink with per-byte hold-off.
// Assumes: mode and cfg_len change only while no packet is open.
module egress_deframer #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    parameter int LVL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [LEN_W-1:0]  cfg_len_i,
    input  logic [DATA_W-1:0] buf_data_i,
    input  logic              buf_last_i,
    input  logic [LVL_W-1:0]  buf_level_i,
    output logic              buf_pop_o,
    input  logic              sink_en_i,
    output logic              avail_o,
    output logic [DATA_W-1:0] data_o,
    output logic              sync_o,
    output logic              sync_oe_o
);

    logic             load;
    logic             load_first;
    logic             load_last;
    logic             slot_free;
    logic             pkt_open;
    logic [LEN_W-1:0] next_idx;

    dfr_pos_counter #(.LEN_W(LEN_W)) pos_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .load_is_last (load_last),
        .pkt_open     (pkt_open),
        .next_idx     (next_idx)
    );

    dfr_load_ctrl #(.LEN_W(LEN_W), .LVL_W(LVL_W)) ctrl_i (
        .mode          (mode_i),
        .cfg_len       (cfg_len_i),
        .buf_level     (buf_level_i),
        .buf_last      (buf_last_i),
        .pkt_open      (pkt_open),
        .next_idx      (next_idx),
        .slot_free     (slot_free),
        .load          (load),
        .load_is_first (load_first),
        .load_is_last  (load_last)
    );

    dfr_out_stage #(.DATA_W(DATA_W)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_i),
        .sink_en   (sink_en_i),
        .load      (load),
        .in_data   (buf_data_i),
        .in_first  (load_first),
        .in_last   (load_last),
        .slot_free (slot_free),
        .avail     (avail_o),
        .data      (data_o),
        .sync      (sync_o),
        .sync_oe   (sync_oe_o)
    );

    assign buf_pop_o = load;

endmodule

// File: rtl/dfr_checker.sv
// Port-level protocol checker for the egress deframer, bound to the top.
module dfr_checker #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    parameter int LVL_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic [LEN_W-1:0]  cfg_len_i,
    input logic [LVL_W-1:0]  buf_level_i,
    input logic              buf_pop_o,
    input logic              sink_en_i,
    input logic              avail_o,
    input logic [DATA_W-1:0] data_o,
    input logic              sync_o,
    input logic              sync_oe_o
);

    localparam int CMP_W = (LVL_W > LEN_W) ? LVL_W : LEN_W;

    assert_pop_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop_o |-> (!avail_o || sink_en_i));

    assert_pop_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop_o |-> (buf_level_i != '0));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (avail_o && !sink_en_i) |=> (avail_o && $stable(data_o) && $stable(sync_o)));

    assert_wait_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'd2 && !avail_o && CMP_W'(buf_level_i) < CMP_W'(cfg_len_i))
        |-> !buf_pop_o);

    assert_oe_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 || mode_i == 2'd3) |-> !sync_oe_o);

    assert_oe_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 || mode_i == 2'd2) |-> sync_oe_o);

    assert_idle_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !avail_o |-> !sync_o);

    assert_idle_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!avail_o && !buf_pop_o) |=> $stable(data_o));

endmodule

bind egress_deframer dfr_checker #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .LVL_W(LVL_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .cfg_len_i   (cfg_len_i),
    .buf_level_i (buf_level_i),
    .buf_pop_o   (buf_pop_o),
    .sink_en_i   (sink_en_i),
    .avail_o     (avail_o),
    .data_o      (data_o),
    .sync_o      (sync_o),
    .sync_oe_o   (sync_oe_o)
);

// File: tb/egress_deframer_tb_top.sv
module egress_deframer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [7:0] cfg_len = 8'd4;
    logic       sink_en = 1'b0;
    logic       buf_pop, avail, sync, sync_oe;
    logic [7:0] data;
    logic [9:0] level;

    // Bench-side show-ahead buffer model.
    logic [7:0] mem_d [64];
    logic       mem_l [64];
    logic [6:0] wr_p = '0;
    logic [6:0] rd_p = '0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    assign level = {3'b0, wr_p - rd_p};

    always @(posedge clk) begin
        if (!rst_n) rd_p <= '0;
        else if (buf_pop) rd_p <= rd_p + 1'b1;
    end

    egress_deframer dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .cfg_len_i(cfg_len),
        .buf_data_i(mem_d[rd_p[5:0]]), .buf_last_i(mem_l[rd_p[5:0]]),
        .buf_level_i(level), .buf_pop_o(buf_pop), .sink_en_i(sink_en),
        .avail_o(avail), .data_o(data), .sync_o(sync), .sync_oe_o(sync_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic l);
        mem_d[wr_p[5:0]] = d;
        mem_l[wr_p[5:0]] = l;
        wr_p = wr_p + 1'b1;
    endtask

    // Wait for the next handed-over byte and check its value and marker.
    task automatic take(input string req, input logic [7:0] ed, input logic es, input bit now);
        int waited = 0;
        @(negedge clk);
        while (!(avail && sink_en) && waited < 40) begin
            waited++;
            @(negedge clk);
        end
        if (now) check({req, " no gap"}, waited, 0);
        check({req, " data"}, data, ed);
        check({req, " sync"}, sync, es);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 avail", avail, 0);
        check("R1 sync", sync, 0);
        check("R1 pop", buf_pop, 0);
        check("R1 data", data, 0);
    endtask

    task automatic t_fixed;
        mode = 2'd0; cfg_len = 8'd4; sink_en = 1'b1;
        for (int i = 0; i < 3; i++) push(8'h10 + 8'(i), 1'b0);
        repeat (5) begin
            @(negedge clk);
            check("R4 no start", avail, 0);
        end
        push(8'h13, 1'b0);
        @(negedge clk);
        check("R4 start", avail, 1);
        check("R4 first byte", data, 8'h10);
        check("R5 oe mode0", sync_oe, 0);
        for (int i = 1; i < 4; i++) take("R2 R10", 8'h10 + 8'(i), 1'b0, 1'b1);
        @(negedge clk);
        check("R8 avail low", avail, 0);
        mode = 2'd3;
        @(negedge clk);
        check("R5 oe mode3", sync_oe, 0);
    endtask

    task automatic t_first_b2b;
        mode = 2'd1; cfg_len = 8'd3; sink_en = 1'b1;
        @(negedge clk);
        check("R5 oe mode1", sync_oe, 1);
        for (int i = 0; i < 6; i++) push(8'h20 + 8'(i), 1'b0);
        take("R6", 8'h20, 1'b1, 1'b0);
        for (int i = 1; i < 6; i++)
            take("R6 R8 R10", 8'h20 + 8'(i), (i == 3), 1'b1);
        @(negedge clk);
        check("R8 end", avail, 0);
        check("R9 sync idle", sync, 0);
        check("R9 data held", data, 8'h25);
        repeat (3) @(negedge clk);
        check("R9 data still held", data, 8'h25);
    endtask

    task automatic t_hold;
        mode = 2'd1; cfg_len = 8'd4; sink_en = 1'b0;
        for (int i = 0; i < 4; i++) push(8'h30 + 8'(i), 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R3 avail", avail, 1);
        repeat (3) begin
            @(negedge clk);
            check("R3 data", data, 8'h30);
            check("R3 sync", sync, 1);
            check("R3 avail held", avail, 1);
        end
        sink_en = 1'b1;
        @(negedge clk);
        check("R2 after hold", data, 8'h31);
        sink_en = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check("R3 mid hold", data, 8'h31);
        end
        sink_en = 1'b1;
        take("R2", 8'h32, 1'b0, 1'b0);
        take("R2", 8'h33, 1'b0, 1'b1);
        @(negedge clk);
        check("R8 end hold", avail, 0);
    endtask

    task automatic t_last;
        mode = 2'd2; sink_en = 1'b1;
        @(negedge clk);
        check("R5 oe mode2", sync_oe, 1);
        push(8'h40, 1'b0); push(8'h41, 1'b1);
        push(8'h42, 1'b0); push(8'h43, 1'b0); push(8'h44, 1'b1);
        take("R7", 8'h40, 1'b0, 1'b0);
        take("R7", 8'h41, 1'b1, 1'b1);
        take("R7", 8'h42, 1'b0, 1'b1);
        take("R7", 8'h43, 1'b0, 1'b1);
        take("R7", 8'h44, 1'b1, 1'b1);
        @(negedge clk);
        check("R8 last end", avail, 0);
        push(8'h50, 1'b0);
        take("R7 single", 8'h50, 1'b0, 1'b0);
        repeat (2) begin
            @(negedge clk);
            check("R9 starve", avail, 0);
            check("R9 starve sync", sync, 0);
        end
        push(8'h51, 1'b1);
        take("R7 resume", 8'h51, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_fixed();
        t_first_b2b();
        t_hold();
        t_last();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule